// File: doc/BRIEF.md
# Spare-Register Prefetch Injector

This block sits in the issue path of a throughput core next to a load-pair detector. The detector has already recognised a loop in which a strided "neighbor" load yields an index and a dependent "attribute" load reads from a base address plus that index. For such a loop the injector adds operations to the issue stream that fetch, one iteration ahead, the next neighbor value into one spare register and the matching attribute into a second spare register. On the next iteration it replaces both demand loads with register moves from those spares.

The spares are registers that no thread is using. A prefetched value stays in its spare until the demand move has read it, so evicting the same line from the data cache does not lose it. Every prefetch response is also sent to the data cache as a fill. Each spare carries a valid bit, an address tag, an in-flight flag and a ready flag. A move replaces a load only when the spare's tag equals the demand address. If a move is needed before its response has returned, the incoming stream is stalled until the response arrives.

Operation kinds on the input are encoded 0 other, 1 neighbor load, 2 attribute load, 3 branch. Output operation codes are 0 pass-through, 1 neighbor prefetch load into spare A, 2 address add into spare B, 3 attribute prefetch load into spare B, 4 move from a spare. The output stream is never back-pressured.

Top module: `spare_prefetch_inject`

## Requirements
- R1: After a neighbor load (kind 1) is accepted while injection is allowed, the next output operation is a neighbor prefetch (code 1, destination `spare_reg_a`). Its memory request uses slot 0 and address equal to that load's address plus `cfg_stride`.
- R2: After an attribute load (kind 2) is accepted while injection is allowed and spare A is valid, the block emits an add (code 2, sources `spare_reg_a` and `cfg_base_reg`, destination `spare_reg_b`). It then emits an attribute prefetch (code 3) whose slot-1 request address is `cfg_base` plus the value returned for spare A.
- R3: A neighbor load whose address equals valid spare A's tag leaves as a move (code 4) with `out_src` = `spare_reg_a`, and spare A is freed. An attribute load that matches spare B leaves as a move with `out_src` = `spare_reg_b`, and spare B is freed.
- R4: A new prefetch into a spare is requested only when that spare is neither holding an unconsumed value nor waiting for a response.
- R5: Every memory response is forwarded as a cache fill in the same cycle. The fill carries the response data and the address that was requested for that slot.
- R6: No operation is injected when `spare_avail` is low or `cfg_en` is low. Matching loads are still replaced by moves in that case.
- R7: A neighbor or attribute load that misses a valid spare's tag passes through unchanged (code 0), and both spares are invalidated.
- R8: A branch (kind 3) with `in_taken` low invalidates both spares, so later loads to the old tags pass through.
- R9: A move whose prefetch response has not yet returned holds `in_ready` low and emits nothing until the response arrives. The move then issues.
- R10: During and after reset, `in_ready` is 1, and `out_valid` and `mem_req_valid` are 0 while no input is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Confirmed load pair present |
| cfg_stride | input | AW | Neighbor-load stride |
| cfg_base | input | AW | Value of the base register |
| cfg_base_reg | input | RW | Index of the base register |
| spare_avail | input | 1 | Two spare registers are allocated |
| spare_reg_a | input | RW | Index of spare A (neighbor value) |
| spare_reg_b | input | RW | Index of spare B (attribute value) |
| in_valid | input | 1 | Incoming operation valid |
| in_ready | output | 1 | Incoming operation accepted this cycle |
| in_kind | input | 2 | 0 other, 1 neighbor load, 2 attribute load, 3 branch |
| in_taken | input | 1 | Branch taken |
| in_dst | input | RW | Destination register |
| in_addr | input | AW | Load address |
| out_valid | output | 1 | Outgoing operation valid |
| out_op | output | 3 | 0 pass, 1 neighbor prefetch, 2 add, 3 attribute prefetch, 4 move |
| out_dst | output | RW | Destination register |
| out_src | output | RW | First source register |
| out_src2 | output | RW | Second source register (add only) |
| out_addr | output | AW | Load address or computed address |
| mem_req_valid | output | 1 | Prefetch request |
| mem_req_slot | output | 1 | 0 spare A, 1 spare B |
| mem_req_addr | output | AW | Prefetch address |
| mem_rsp_valid | input | 1 | Prefetch response |
| mem_rsp_slot | input | 1 | Slot of the response |
| mem_rsp_data | input | AW | Response data |
| fill_valid | output | 1 | Cache fill |
| fill_addr | output | AW | Fill address |
| fill_data | output | AW | Fill data |

## Verification
The hardest situation to reach is a move that arrives while its own prefetch is still in flight. In steady state the attribute-side add already waits for spare A's response, which hides any later stall. The bench therefore raises its memory latency and sends two neighbor loads back to back with no attribute load between them. The second load hits spare A before the response has returned. Stale responses are also covered: a mismatch invalidates spare B while its prefetch is in flight, and the following attribute load must still pass through.

// File: rtl/spfx_pkg.sv
package spfx_pkg;
  typedef enum logic [1:0] {K_OTHER = 2'd0, K_NLOAD = 2'd1, K_ALOAD = 2'd2, K_BRANCH = 2'd3} kind_e;
  typedef enum logic [2:0] {
    OP_PASS = 3'd0, OP_PFN = 3'd1, OP_ADD = 3'd2, OP_PFA = 3'd3, OP_MOV = 3'd4
  } oop_e;
  typedef enum logic [1:0] {S_RUN, S_INJ_N, S_INJ_ADD, S_INJ_A} st_e;
endpackage

// File: rtl/spfx_slot.sv
module spfx_slot #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic [AW-1:0] tag_i,
  input  logic          clr_i,
  input  logic          rsp_i,
  input  logic [AW-1:0] data_i,
  output logic          valid_o,
  output logic [AW-1:0] tag_o,
  output logic          busy_o,
  output logic          rdy_o,
  output logic [AW-1:0] data_o
);
  logic          valid_d, busy_d, rdy_d;
  logic [AW-1:0] tag_d, data_d;
  logic          tag_en, data_en;

  always_comb begin
    valid_d = valid_o;
    busy_d  = busy_o;
    rdy_d   = rdy_o;
    tag_en  = set_i;
    tag_d   = tag_i;
    data_en = rsp_i && valid_o && !clr_i;
    data_d  = data_i;
    if (rsp_i) begin
      busy_d = 1'b0;
      if (valid_o && !clr_i) rdy_d = 1'b1;
    end
    if (clr_i) begin
      valid_d = 1'b0;
      rdy_d   = 1'b0;
    end
    if (set_i) begin
      valid_d = 1'b1;
      busy_d  = 1'b1;
      rdy_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      busy_o  <= 1'b0;
      rdy_o   <= 1'b0;
      tag_o   <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_d;
      busy_o  <= busy_d;
      rdy_o   <= rdy_d;
      if (tag_en)  tag_o  <= tag_d;
      if (data_en) data_o <= data_d;
    end
  end

  // R4: never refill a spare that holds an unread value or awaits a response
  assert_no_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |-> (!valid_o && !busy_o));
  // R4: a response only returns for an outstanding request
  assert_rsp_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_i |-> busy_o);
endmodule

// File: rtl/spfx_seq.sv
module spfx_seq
  import spfx_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en_i,
  input  logic               spare_avail_i,
  input  logic [AW-1:0]      cfg_stride_i,
  input  logic [AW-1:0]      cfg_base_i,
  input  logic               in_valid_i,
  input  logic [1:0]         in_kind_i,
  input  logic               in_taken_i,
  input  logic [AW-1:0]      in_addr_i,
  input  logic [1:0]         s_valid_i,
  input  logic [1:0][AW-1:0] s_tag_i,
  input  logic [1:0]         s_busy_i,
  input  logic [1:0]         s_rdy_i,
  input  logic [AW-1:0]      s0_data_i,
  output logic               in_ready_o,
  output logic               out_valid_o,
  output logic [2:0]         out_op_o,
  output logic [AW-1:0]      out_addr_o,
  output logic               mov_slot_o,
  output logic [1:0]         set_o,
  output logic [1:0]         clr_o,
  output logic               req_valid_o,
  output logic               req_slot_o,
  output logic [AW-1:0]      req_addr_o
);
  st_e           state, nxt;
  logic [AW-1:0] nl_q, nl_d, attr;
  logic          hit0, hit1, gate, nl_en;

  always_comb begin
    nxt         = state;
    nl_d        = in_addr_i;
    nl_en       = 1'b0;
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    out_op_o    = OP_PASS;
    out_addr_o  = in_addr_i;
    mov_slot_o  = 1'b0;
    set_o       = 2'b00;
    clr_o       = 2'b00;
    req_valid_o = 1'b0;
    req_slot_o  = 1'b0;
    req_addr_o  = nl_q + cfg_stride_i;
    gate        = cfg_en_i && spare_avail_i;
    attr        = cfg_base_i + s0_data_i;
    hit0        = s_valid_i[0] && (s_tag_i[0] == in_addr_i);
    hit1        = s_valid_i[1] && (s_tag_i[1] == in_addr_i);
    case (state)
      S_RUN: begin
        in_ready_o  = 1'b1;
        out_valid_o = in_valid_i;
        if (in_valid_i) begin
          case (kind_e'(in_kind_i))
            K_NLOAD: begin
              if (hit0 && !s_rdy_i[0]) begin
                in_ready_o  = 1'b0;
                out_valid_o = 1'b0;
              end else begin
                nl_en = 1'b1;
                if (hit0) begin
                  out_op_o = OP_MOV;
                  clr_o[0] = 1'b1;
                end else if (s_valid_i[0]) begin
                  clr_o = 2'b11;
                end
                if (gate) nxt = S_INJ_N;
              end
            end
            K_ALOAD: begin
              if (hit1 && !s_rdy_i[1]) begin
                in_ready_o  = 1'b0;
                out_valid_o = 1'b0;
              end else if (hit1) begin
                out_op_o   = OP_MOV;
                mov_slot_o = 1'b1;
                clr_o[1]   = 1'b1;
                if (gate && s_valid_i[0]) nxt = S_INJ_ADD;
              end else if (s_valid_i[1]) begin
                clr_o = 2'b11;
              end else if (gate && s_valid_i[0]) begin
                nxt = S_INJ_ADD;
              end
            end
            K_BRANCH: if (!in_taken_i) clr_o = 2'b11;
            default: ;
          endcase
        end
      end
      S_INJ_N: begin
        if (!s_busy_i[0]) begin
          out_valid_o = 1'b1;
          out_op_o    = OP_PFN;
          out_addr_o  = req_addr_o;
          req_valid_o = 1'b1;
          set_o[0]    = 1'b1;
          nxt         = S_RUN;
        end
      end
      S_INJ_ADD: begin
        if (s_rdy_i[0] && !s_busy_i[1]) begin
          out_valid_o = 1'b1;
          out_op_o    = OP_ADD;
          out_addr_o  = attr;
          nxt         = S_INJ_A;
        end
      end
      default: begin
        out_valid_o = 1'b1;
        out_op_o    = OP_PFA;
        out_addr_o  = attr;
        req_valid_o = 1'b1;
        req_slot_o  = 1'b1;
        req_addr_o  = attr;
        set_o[1]    = 1'b1;
        nxt         = S_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_RUN;
      nl_q  <= '0;
    end else begin
      state <= nxt;
      if (nl_en) nl_q <= nl_d;
    end
  end

  // R9: a move only leaves once the spare it reads has its data
  assert_mov_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_op_o == OP_MOV) |-> s_rdy_i[mov_slot_o]);
  // R6: injected operations are preceded by an accepted load while allowed
  assert_inject_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && nxt != S_RUN) |-> (cfg_en_i && spare_avail_i && in_valid_i));
endmodule

// File: rtl/spare_prefetch_inject.sv
module spare_prefetch_inject
  import spfx_pkg::*;
#(
  parameter int AW = 16,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic [AW-1:0] cfg_stride,
  input  logic [AW-1:0] cfg_base,
  input  logic [RW-1:0] cfg_base_reg,
  input  logic          spare_avail,
  input  logic [RW-1:0] spare_reg_a,
  input  logic [RW-1:0] spare_reg_b,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_kind,
  input  logic          in_taken,
  input  logic [RW-1:0] in_dst,
  input  logic [AW-1:0] in_addr,
  output logic          out_valid,
  output logic [2:0]    out_op,
  output logic [RW-1:0] out_dst,
  output logic [RW-1:0] out_src,
  output logic [RW-1:0] out_src2,
  output logic [AW-1:0] out_addr,
  output logic          mem_req_valid,
  output logic          mem_req_slot,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic          mem_rsp_slot,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          fill_valid,
  output logic [AW-1:0] fill_addr,
  output logic [AW-1:0] fill_data
);
  localparam int NSPARE = 2;

  logic                   rst_meta, rst_s;
  logic [NSPARE-1:0]      s_valid, s_busy, s_rdy, set, clr;
  logic [NSPARE-1:0][AW-1:0] s_tag, s_data;
  logic                   mov_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  for (genvar g = 0; g < NSPARE; g++) begin : g_slot
    spfx_slot #(.AW(AW)) u_slot (
      .clk    (clk),
      .rst_n  (rst_s),
      .set_i  (set[g]),
      .tag_i  (mem_req_addr),
      .clr_i  (clr[g]),
      .rsp_i  (mem_rsp_valid && (mem_rsp_slot == 1'(g))),
      .data_i (mem_rsp_data),
      .valid_o(s_valid[g]),
      .tag_o  (s_tag[g]),
      .busy_o (s_busy[g]),
      .rdy_o  (s_rdy[g]),
      .data_o (s_data[g])
    );
  end

  spfx_seq #(.AW(AW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_s),
    .cfg_en_i     (cfg_en),
    .spare_avail_i(spare_avail),
    .cfg_stride_i (cfg_stride),
    .cfg_base_i   (cfg_base),
    .in_valid_i   (in_valid),
    .in_kind_i    (in_kind),
    .in_taken_i   (in_taken),
    .in_addr_i    (in_addr),
    .s_valid_i    (s_valid),
    .s_tag_i      (s_tag),
    .s_busy_i     (s_busy),
    .s_rdy_i      (s_rdy),
    .s0_data_i    (s_data[0]),
    .in_ready_o   (in_ready),
    .out_valid_o  (out_valid),
    .out_op_o     (out_op),
    .out_addr_o   (out_addr),
    .mov_slot_o   (mov_slot),
    .set_o        (set),
    .clr_o        (clr),
    .req_valid_o  (mem_req_valid),
    .req_slot_o   (mem_req_slot),
    .req_addr_o   (mem_req_addr)
  );

  always_comb begin
    out_dst  = in_dst;
    out_src  = '0;
    out_src2 = '0;
    case (oop_e'(out_op))
      OP_PFN: out_dst = spare_reg_a;
      OP_ADD: begin
        out_dst  = spare_reg_b;
        out_src  = spare_reg_a;
        out_src2 = cfg_base_reg;
      end
      OP_PFA: begin
        out_dst = spare_reg_b;
        out_src = spare_reg_b;
      end
      OP_MOV: out_src = mov_slot ? spare_reg_b : spare_reg_a;
      default: ;
    endcase
  end

  assign fill_valid = mem_rsp_valid;
  assign fill_addr  = s_tag[mem_rsp_slot];
  assign fill_data  = mem_rsp_data;

  // R8: a not-taken branch leaves both spares invalid
  assert_flush_branch_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (in_valid && in_ready && in_kind == 2'd3 && !in_taken) |=> (s_valid == 2'b00));
  // R7: a neighbor load missing a valid spare A invalidates it
  assert_flush_miss_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (in_valid && in_ready && in_kind == 2'd1 && s_valid[0] && s_tag[0] != in_addr)
      |=> !s_valid[0]);
  // R3: a move from spare A stands for a load to exactly its tag
  assert_mov_tag_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && out_op == 3'd4 && out_src == spare_reg_a && spare_reg_a != spare_reg_b)
      |-> (s_valid[0] && s_tag[0] == in_addr));
endmodule

// File: tb/tb_spare_prefetch_inject.sv
module tb_spare_prefetch_inject;
  localparam int AW = 16;
  localparam int RW = 5;
  localparam logic [RW-1:0] SPA = 5'd20;
  localparam logic [RW-1:0] SPB = 5'd21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b1;
  logic [AW-1:0] cfg_stride = 16'd4;
  logic [AW-1:0] cfg_base = 16'h1000;
  logic [RW-1:0] cfg_base_reg = 5'd7;
  logic spare_avail = 1'b1;
  logic in_valid = 1'b0, in_taken = 1'b0;
  logic [1:0] in_kind = 2'd0;
  logic [RW-1:0] in_dst = 5'd3;
  logic [AW-1:0] in_addr = '0;
  logic in_ready, out_valid, mem_req_valid, mem_req_slot, fill_valid;
  logic [2:0] out_op;
  logic [RW-1:0] out_dst, out_src, out_src2;
  logic [AW-1:0] out_addr, mem_req_addr, fill_addr, fill_data;
  logic mem_rsp_valid = 1'b0, mem_rsp_slot = 1'b0;
  logic [AW-1:0] mem_rsp_data = '0;

  int checks = 0, fails = 0, cyc = 0, lat = 3;

  spare_prefetch_inject #(.AW(AW), .RW(RW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_stride(cfg_stride),
    .cfg_base(cfg_base), .cfg_base_reg(cfg_base_reg), .spare_avail(spare_avail),
    .spare_reg_a(SPA), .spare_reg_b(SPB), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_taken(in_taken), .in_dst(in_dst), .in_addr(in_addr),
    .out_valid(out_valid), .out_op(out_op), .out_dst(out_dst), .out_src(out_src),
    .out_src2(out_src2), .out_addr(out_addr), .mem_req_valid(mem_req_valid),
    .mem_req_slot(mem_req_slot), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_slot(mem_rsp_slot),
    .mem_rsp_data(mem_rsp_data), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_data(fill_data)
  );

  always #10 clk = ~clk;

  function automatic logic [AW-1:0] dfun(input logic [AW-1:0] a);
    return (a * 16'd3) & 16'h0FFF;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // memory model: one outstanding request per slot, fixed latency
  logic          pend [2];
  logic [AW-1:0] paddr [2];
  int            pcnt [2];
  initial begin
    pend[0] = 0; pend[1] = 0;
    forever begin
      @(negedge clk); #2;
      mem_rsp_valid = 1'b0;
      if (rst_n && mem_req_valid) begin
        pend[mem_req_slot]  = 1'b1;
        paddr[mem_req_slot] = mem_req_addr;
        pcnt[mem_req_slot]  = lat;
      end
      for (int s = 0; s < 2; s++) if (pend[s] && pcnt[s] > 0) pcnt[s]--;
      for (int s = 0; s < 2; s++) begin
        if (!mem_rsp_valid && pend[s] && pcnt[s] == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_slot  = s[0];
          mem_rsp_data  = dfun(paddr[s]);
          pend[s]       = 1'b0;
          #1;
          chk("R5", "fill_valid", int'(fill_valid), 1);
          chk("R5", "fill_addr", int'(fill_addr), int'(paddr[s]));
          chk("R5", "fill_data", int'(fill_data), int'(dfun(paddr[s])));
        end
      end
    end
  end

  task automatic send(input logic [1:0] k, input logic t, input logic [AW-1:0] a,
                      output logic [2:0] op, output logic [RW-1:0] src,
                      output int stalls, output int inj, output logic [AW-1:0] last);
    stalls = 0; inj = 0; last = '0;
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_taken = t; in_addr = a;
    #1;
    while (!in_ready && stalls < 200) begin
      if (out_valid) chk("R9", "out_valid during stall", 1, 0);
      stalls++;
      @(negedge clk); #1;
    end
    op = out_valid ? out_op : 3'd7;
    src = out_src;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    for (int n = 0; n < 200; n++) begin
      if (out_valid && out_op >= 3'd1 && out_op <= 3'd3) begin
        inj++;
        if (out_op == 3'd2) begin
          chk("R2", "add src", int'(out_src), int'(SPA));
          chk("R2", "add src2", int'(out_src2), int'(cfg_base_reg));
          chk("R2", "add dst", int'(out_dst), int'(SPB));
        end
        if (out_op == 3'd1) chk("R1", "pfn dst", int'(out_dst), int'(SPA));
      end
      if (mem_req_valid) last = mem_req_addr;
      if (in_ready) break;
      @(negedge clk); #1;
    end
  endtask

  // {kind, taken, addr, exp_op, exp_src(0 none,1 A,2 B), exp_inj, exp_last_req}
  localparam int NV = 13;
  localparam logic [41:0] VEC [NV] = '{
    {2'd1, 1'b0, 16'h0100, 3'd0, 2'd0, 2'd1, 16'h0104},
    {2'd2, 1'b0, 16'h2000, 3'd0, 2'd0, 2'd2, 16'h130C},
    {2'd0, 1'b0, 16'h0000, 3'd0, 2'd0, 2'd0, 16'h0000},
    {2'd1, 1'b0, 16'h0104, 3'd4, 2'd1, 2'd1, 16'h0108},
    {2'd2, 1'b0, 16'h130C, 3'd4, 2'd2, 2'd2, 16'h1318},
    {2'd3, 1'b1, 16'h0000, 3'd0, 2'd0, 2'd0, 16'h0000},
    {2'd1, 1'b0, 16'h0108, 3'd4, 2'd1, 2'd1, 16'h010C},
    {2'd2, 1'b0, 16'h1318, 3'd4, 2'd2, 2'd2, 16'h1324},
    {2'd1, 1'b0, 16'h0200, 3'd0, 2'd0, 2'd1, 16'h0204},
    {2'd2, 1'b0, 16'h1324, 3'd0, 2'd0, 2'd2, 16'h160C},
    {2'd3, 1'b0, 16'h0000, 3'd0, 2'd0, 2'd0, 16'h0000},
    {2'd1, 1'b0, 16'h0204, 3'd0, 2'd0, 2'd1, 16'h0208},
    {2'd2, 1'b0, 16'h160C, 3'd0, 2'd0, 2'd2, 16'h1618}
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R1"; 1: return "R2"; 3, 4, 6, 7: return "R3";
      8, 9: return "R7"; 11, 12: return "R8";
      default: return "R3";
    endcase
  endfunction

  initial begin
    logic [2:0] op;
    logic [RW-1:0] src;
    logic [AW-1:0] last;
    int stalls, inj;
    repeat (3) @(negedge clk);
    #1;
    chk("R10", "in_ready in reset", int'(in_ready), 1);
    chk("R10", "out_valid in reset", int'(out_valid), 0);
    chk("R10", "mem_req_valid in reset", int'(mem_req_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    chk("R10", "out_valid after reset", int'(out_valid), 0);
    chk("R10", "mem_req_valid after reset", int'(mem_req_valid), 0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][41:40], VEC[i][39], VEC[i][38:23], op, src, stalls, inj, last);
      chk(vtag(i), $sformatf("vec%0d op", i), int'(op), int'(VEC[i][22:20]));
      if (VEC[i][19:18] != 2'd0)
        chk(vtag(i), $sformatf("vec%0d src", i), int'(src),
            int'(VEC[i][19:18] == 2'd1 ? SPA : SPB));
      chk(vtag(i), $sformatf("vec%0d injected", i), inj, int'(VEC[i][17:16]));
      if (VEC[i][17:16] != 2'd0)
        chk(vtag(i), $sformatf("vec%0d prefetch addr", i), int'(last), int'(VEC[i][15:0]));
    end

    // R9: back-to-back neighbor loads with slow memory
    lat = 10;
    send(2'd1, 1'b0, 16'h0208, op, src, stalls, inj, last);
    chk("R3", "nl 208 op", int'(op), 4);
    chk("R1", "nl 208 prefetch", int'(last), 16'h020C);
    send(2'd1, 1'b0, 16'h020C, op, src, stalls, inj, last);
    chk("R9", "stalled move op", int'(op), 4);
    chk("R9", "stall seen", int'(stalls > 0), 1);
    chk("R1", "nl 20C prefetch", int'(last), 16'h0210);

    // R6: no spares allocated, moves still substitute
    lat = 3;
    spare_avail = 1'b0;
    send(2'd2, 1'b0, 16'h1618, op, src, stalls, inj, last);
    chk("R6", "al move op", int'(op), 4);
    chk("R6", "al move src", int'(src), int'(SPB));
    chk("R6", "al no inject", inj, 0);
    send(2'd1, 1'b0, 16'h0210, op, src, stalls, inj, last);
    chk("R6", "nl move op", int'(op), 4);
    chk("R6", "nl no inject", inj, 0);
    send(2'd1, 1'b0, 16'h0214, op, src, stalls, inj, last);
    chk("R4", "consumed spare passes", int'(op), 0);
    chk("R6", "pass no inject", inj, 0);
    spare_avail = 1'b1;
    cfg_en = 1'b0;
    send(2'd1, 1'b0, 16'h0300, op, src, stalls, inj, last);
    chk("R6", "cfg_en low no inject", inj, 0);

    repeat (20) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule